// File: doc/BRIEF.md
# Dual-Output Waveform Timer

This block is one timer channel that produces two pulse-width-modulated outputs from a single up-counter. The counter runs from a prescaled version of the system clock or from a slow tick, and it returns to zero when it reaches the shared period value. Each output changes level only through programmable actions. Each action sets or clears its output and is tied to one event: a match on that output's own duty value, a match on the shared period value, or a software trigger.

Software writes five word-wide locations through a one-cycle write strobe: a mode word, two duty values, the period value, and a command word. For a normal-polarity waveform, the output is set on the period match and cleared on the duty match. The software trigger's action is set to "set" so that the first period starts high. Inverted polarity swaps the two compare actions. A constant level is produced by leaving both compare actions at "none" and letting the software trigger place the level.

Top module: `dual_wave_timer`

## Requirements
- R1: After reset both outputs are low and the counter is stopped. Writing mode, duty and period values without a command leaves both outputs unchanged, even when compare actions are programmed.
- R2: A write to address 4 with bit 2 set is a software trigger. It applies each output's trigger action: code 01 sets the output, 10 clears it, and 00 and 11 leave it unchanged.
- R3: While running, the counter advances by one per tick and returns to zero on the tick where it equals the period value P (address 3). Each output waveform therefore repeats every (P+1)·N system clocks, where N is the clocks per tick.
- R4: Output A is programmed with period-match action "set" (mode bits 6:5 = 01), duty-match action "clear" (bits 4:3 = 10) and trigger action "set" (bits 8:7 = 01). With duty value D (address 1), it is then high for (D+1)·N clocks of each period.
- R5: With the two compare actions swapped (period match clears, duty match sets), the output is low for (D+1)·N clocks and high for (P−D)·N clocks of each period.
- R6: Mode bits 2:0 select the tick source: 0, 1, 2 and 3 give N = 2, 8, 32 and 128. Code 4 gives one tick per cycle in which slow_tick is high. Codes 5 to 7 give no ticks, so the outputs hold their levels.
- R7: Output B uses its own duty value (address 2) and its own action fields: duty match in bits 10:9, period match in bits 12:11, trigger in bits 14:13. It shares the period and the tick source with output A.
- R8: Command bit 0 starts the clock and bit 1 stops it; stop wins if both are set. A software trigger always returns the counter and prescaler to zero. Trigger with start therefore begins a fresh period. Trigger with stop places the trigger levels and then holds them.
- R9: When both compare actions of an output are "none", the output keeps the level placed by the last software trigger while the counter runs. This is how duty 0 and duty equal to period are produced.
- R10: When several events with active actions fall on one output in the same cycle, the software trigger wins over the period match, and the period match wins over the duty match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slow_tick | input | 1 | Slow time-base strobe, one clock wide, used by clock-select code 4 |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 3 | 0 mode, 1 duty A, 2 duty B, 3 period, 4 command |
| wr_data | input | CNT_W | Write data |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |

## Verification
Two pairs of events can fall in the same cycle, and both are provoked on purpose. In the first, the bench times a trigger-only command so that the write is captured on the very edge where the counter's duty match clears output A. The output must stay at the trigger's "set" level, and the next clear must come one full high time later, which shows that the restart happened. In the second, the duty value equals the period value with the duty match clearing and the period match setting. Output A must go high at the first wrap and stay high for many periods.

// File: rtl/wtmr_pkg.sv
package wtmr_pkg;

  // Per-event action applied to an output
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_RSVD = 2'b11
  } act_e;

  // Mode word, LSB first: clk_sel[2:0], a_dm[4:3], a_pm[6:5], a_sw[8:7],
  // b_dm[10:9], b_pm[12:11], b_sw[14:13]
  typedef struct packed {
    act_e       b_sw;
    act_e       b_pm;
    act_e       b_dm;
    act_e       a_sw;
    act_e       a_pm;
    act_e       a_dm;
    logic [2:0] clk_sel;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  localparam logic [2:0] ADDR_MODE   = 3'd0;
  localparam logic [2:0] ADDR_DUTY_A = 3'd1;
  localparam logic [2:0] ADDR_DUTY_B = 3'd2;
  localparam logic [2:0] ADDR_PERIOD = 3'd3;
  localparam logic [2:0] ADDR_CMD    = 3'd4;

  localparam int CMD_START = 0;
  localparam int CMD_STOP  = 1;
  localparam int CMD_TRIG  = 2;
  localparam int CMD_W     = 3;

  localparam int         PRE_W    = 7;
  localparam logic [2:0] SEL_SLOW = 3'd4;

endpackage

// File: rtl/wtmr_prescale.sv
module wtmr_prescale
  import wtmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [2:0] sel,
  input  logic       slow_tick,
  output logic       tick
);

  logic [PRE_W-1:0] pcnt_q, pcnt_d;
  logic [PRE_W-1:0] term;
  logic             fast_sel;

  assign fast_sel = (sel < SEL_SLOW);

  always_comb begin
    case (sel[1:0])
      2'd0:    term = PRE_W'(1);
      2'd1:    term = PRE_W'(7);
      2'd2:    term = PRE_W'(31);
      default: term = PRE_W'(127);
    endcase
  end

  always_comb begin
    if (!run)          tick = 1'b0;
    else if (fast_sel) tick = (pcnt_q == term);
    else               tick = (sel == SEL_SLOW) && slow_tick;
  end

  always_comb begin
    pcnt_d = pcnt_q;
    if (restart)                pcnt_d = '0;
    else if (run && fast_sel)   pcnt_d = tick ? '0 : pcnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R6: a divided tick is never followed by another tick on the next cycle
  assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fast_sel && !restart) |=> (!tick || sel == SEL_SLOW));

endmodule

// File: rtl/wtmr_count.sv
module wtmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             pm_hit
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign pm_hit = tick && (cnt_q == period);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)     cnt_d = '0;
    else if (pm_hit) cnt_d = '0;
    else if (tick)   cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R3: wrap to zero after the tick that meets the period
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == period) |=> (cnt == '0));

  // R8: software trigger always restarts the count
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

  // R6: without a tick or trigger the count holds
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cnt));

endmodule

// File: rtl/wtmr_wave_out.sv
module wtmr_wave_out
  import wtmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty,
  input  logic             pm_hit,
  input  logic             sw_ev,
  input  act_e             dm_act,
  input  act_e             pm_act,
  input  act_e             sw_act,
  output logic             wave
);

  logic dm_hit;
  act_e act_sel;
  logic wave_q, wave_d;

  function automatic logic live(input act_e a);
    return (a == ACT_SET) || (a == ACT_CLR);
  endfunction

  assign dm_hit = tick && (cnt == duty);

  // priority: trigger, then period match, then duty match
  always_comb begin
    act_sel = ACT_NONE;
    if (sw_ev && live(sw_act))       act_sel = sw_act;
    else if (pm_hit && live(pm_act)) act_sel = pm_act;
    else if (dm_hit && live(dm_act)) act_sel = dm_act;
  end

  always_comb begin
    case (act_sel)
      ACT_SET: wave_d = 1'b1;
      ACT_CLR: wave_d = 1'b0;
      default: wave_d = wave_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

  assign wave = wave_q;

  assert_sw_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_ev && sw_act == ACT_SET) |=> wave);

  assert_sw_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_ev && sw_act == ACT_CLR) |=> !wave);

  // R10: period-match set beats a duty-match clear in the same cycle
  assert_pm_over_dm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_ev && pm_hit && pm_act == ACT_SET) |=> wave);

  // R9: with no trigger and no tick the level holds
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_ev && !tick) |=> $stable(wave));

endmodule

// File: rtl/dual_wave_timer.sv
module dual_wave_timer
  import wtmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             out_a,
  output logic             out_b
);

  localparam int NCH = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  logic unused_bits;
  assign unused_bits = ^wr_data[CNT_W-1:MODE_W];

  // command decode
  logic cmd_wr, sw_trig, cmd_start, cmd_stop;
  assign cmd_wr    = wr_en && (wr_addr == ADDR_CMD);
  assign sw_trig   = cmd_wr && wr_data[CMD_TRIG];
  assign cmd_start = cmd_wr && wr_data[CMD_START];
  assign cmd_stop  = cmd_wr && wr_data[CMD_STOP];

  // register file
  mode_t                      mode_q, mode_d;
  logic [CNT_W-1:0]           per_q, per_d;
  logic [NCH-1:0][CNT_W-1:0]  duty_q, duty_d;
  logic                       run_q, run_d;

  always_comb begin
    mode_d = mode_q;
    per_d  = per_q;
    duty_d = duty_q;
    run_d  = run_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_MODE:   mode_d    = mode_t'(wr_data[MODE_W-1:0]);
        ADDR_DUTY_A: duty_d[0] = wr_data;
        ADDR_DUTY_B: duty_d[1] = wr_data;
        ADDR_PERIOD: per_d     = wr_data;
        default: ;
      endcase
    end
    if (cmd_stop)       run_d = 1'b0;
    else if (cmd_start) run_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mode_q <= '0;
      per_q  <= '0;
      duty_q <= '0;
      run_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      per_q  <= per_d;
      duty_q <= duty_d;
      run_q  <= run_d;
    end
  end

  // time base
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             pm_hit;

  wtmr_prescale u_pre (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .run      (run_q),
    .restart  (sw_trig),
    .sel      (mode_q.clk_sel),
    .slow_tick(slow_tick),
    .tick     (tick)
  );

  wtmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .tick   (tick),
    .restart(sw_trig),
    .period (per_q),
    .cnt    (cnt),
    .pm_hit (pm_hit)
  );

  // per-output action fields
  act_e [NCH-1:0] dm_act, pm_act, sw_act;
  always_comb begin
    dm_act[0] = mode_q.a_dm;
    pm_act[0] = mode_q.a_pm;
    sw_act[0] = mode_q.a_sw;
    dm_act[1] = mode_q.b_dm;
    pm_act[1] = mode_q.b_pm;
    sw_act[1] = mode_q.b_sw;
  end

  logic [NCH-1:0] wave;

  for (genvar gi = 0; gi < NCH; gi++) begin : g_wave
    wtmr_wave_out #(.CNT_W(CNT_W)) u_wave (
      .clk   (clk),
      .rst_n (rst_n_s),
      .tick  (tick),
      .cnt   (cnt),
      .duty  (duty_q[gi]),
      .pm_hit(pm_hit),
      .sw_ev (sw_trig),
      .dm_act(dm_act[gi]),
      .pm_act(pm_act[gi]),
      .sw_act(sw_act[gi]),
      .wave  (wave[gi])
    );
  end

  assign out_a = wave[0];
  assign out_b = wave[1];

  // R1: a stopped timer changes its outputs only through a trigger
  assert_stopped_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!run_q && !sw_trig) |=> $stable({out_a, out_b}));

  // R8: stop wins over start
  assert_stop_wins_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmd_stop |=> !run_q);

endmodule

// File: tb/sim_dual_wave_timer.sv
module sim_dual_wave_timer;

  localparam int CW = 16;
  localparam int NONE = 0, SET = 1, CLR = 2, RSV = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slow_tick = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic          out_a, out_b;

  int total = 0;
  int bad = 0;
  int scnt = 0;

  always #2.5 clk = ~clk;

  dual_wave_timer #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_a(out_a), .out_b(out_b)
  );

  // slow time base: one pulse every 10 clocks
  always @(negedge clk) begin
    if (scnt == 9) begin scnt = 0; slow_tick = 1'b1; end
    else begin scnt = scnt + 1; slow_tick = 1'b0; end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] mk(input int sel, input int adm, input int apm,
                                       input int asw, input int bdm, input int bpm,
                                       input int bsw);
    return CW'(sel) | (CW'(adm) << 3) | (CW'(apm) << 5) | (CW'(asw) << 7)
         | (CW'(bdm) << 9) | (CW'(bpm) << 11) | (CW'(bsw) << 13);
  endfunction

  task automatic put(input int a, input logic [CW-1:0] d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
  endtask

  task automatic wr(input int a, input logic [CW-1:0] d);
    @(negedge clk); put(a, d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic setup(input int p, input int da, input int db, input logic [CW-1:0] m);
    wr(3, CW'(p)); wr(1, CW'(da)); wr(2, CW'(db)); wr(0, m);
  endtask

  // measure high time and period of one output in clocks
  task automatic meas(input bit sel_b, output int hi, output int per);
    bit prev, cur;
    int g, lo;
    hi = -1; per = -1; g = 0;
    prev = sel_b ? out_b : out_a;
    while (g < 5000) begin
      @(negedge clk); cur = sel_b ? out_b : out_a;
      if (!prev && cur) break;
      prev = cur; g++;
    end
    if (g >= 5000) return;
    hi = 1;
    while (hi < 5000) begin
      @(negedge clk); if (!(sel_b ? out_b : out_a)) break; hi++;
    end
    lo = 1;
    while (lo < 5000) begin
      @(negedge clk); if (sel_b ? out_b : out_a) break; lo++;
    end
    per = hi + lo;
  endtask

  task automatic t_reset;
    check("R1 out_a after reset", out_a, 0);
    check("R1 out_b after reset", out_b, 0);
    setup(3, 1, 1, mk(0, CLR, SET, SET, CLR, SET, SET));
    repeat (100) @(negedge clk);
    check("R1 out_a no command", out_a, 0);
    check("R1 out_b no command", out_b, 0);
  endtask

  task automatic t_trigger;
    wr(0, mk(5, NONE, NONE, SET, NONE, NONE, CLR));
    wr(4, CW'(6));
    check("R2 trig set A", out_a, 1);
    check("R2 trig clear B", out_b, 0);
    wr(0, mk(5, NONE, NONE, CLR, NONE, NONE, SET));
    wr(4, CW'(4));
    check("R2 trig clear A", out_a, 0);
    check("R2 trig set B", out_b, 1);
    wr(0, mk(5, NONE, NONE, NONE, NONE, NONE, RSV));
    wr(4, CW'(4));
    check("R2 none code keeps A", out_a, 0);
    check("R2 reserved code keeps B", out_b, 1);
  endtask

  task automatic t_divs;
    int hi, per;
    int dv[4] = '{2, 8, 32, 128};
    int pp[4] = '{9, 4, 3, 2};
    int dd[4] = '{3, 1, 1, 1};
    for (int s = 0; s < 4; s++) begin
      setup(pp[s], dd[s], 0, mk(s, CLR, SET, SET, NONE, NONE, NONE));
      wr(4, CW'(5));
      meas(1'b0, hi, per);
      check($sformatf("R4 R6 high time sel=%0d", s), hi, (dd[s] + 1) * dv[s]);
      check($sformatf("R3 R6 period sel=%0d", s), per, (pp[s] + 1) * dv[s]);
    end
  endtask

  task automatic t_slow;
    int hi, per;
    setup(3, 1, 0, mk(4, CLR, SET, SET, NONE, NONE, NONE));
    wr(4, CW'(5));
    meas(1'b0, hi, per);
    check("R6 slow high time", hi, 20);
    check("R6 slow period", per, 40);
    setup(3, 1, 0, mk(5, CLR, SET, CLR, NONE, NONE, NONE));
    wr(4, CW'(5));
    repeat (200) @(negedge clk);
    check("R6 halted select holds", out_a, 0);
  endtask

  task automatic t_invert;
    int hi, per;
    setup(9, 3, 0, mk(0, SET, CLR, CLR, NONE, NONE, NONE));
    wr(4, CW'(5));
    meas(1'b0, hi, per);
    check("R5 inverted high time", hi, (9 - 3) * 2);
    check("R5 inverted period", per, 20);
  endtask

  task automatic t_dual;
    int ha, pa, hb, pb;
    setup(9, 1, 5, mk(0, CLR, SET, SET, CLR, SET, SET));
    wr(4, CW'(5));
    meas(1'b0, ha, pa);
    meas(1'b1, hb, pb);
    check("R7 A high", ha, 4);
    check("R7 B high", hb, 12);
    check("R7 B shares period", pb, 20);
  endtask

  task automatic t_static;
    int ones = 0;
    setup(5, 0, 5, mk(0, NONE, NONE, CLR, NONE, NONE, SET));
    wr(4, CW'(5));
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); ones += out_a; ones += (out_b ? 0 : 1);
    end
    check("R9 static levels (duty 0 low, full duty high)", ones, 0);
  endtask

  task automatic t_cmd;
    int hi, per;
    setup(4, 1, 0, mk(0, CLR, SET, SET, NONE, NONE, NONE));
    wr(4, CW'(5));
    meas(1'b0, hi, per);
    wr(0, mk(0, CLR, SET, CLR, NONE, NONE, NONE));
    wr(4, CW'(6));
    check("R8 trig+stop clears A", out_a, 0);
    repeat (100) @(negedge clk);
    check("R8 stopped A stays low", out_a, 0);
    wr(0, mk(0, CLR, SET, SET, NONE, NONE, NONE));
    wr(4, CW'(7));
    check("R8 trig+stop+start sets A", out_a, 1);
    repeat (100) @(negedge clk);
    check("R8 stop wins, A stays high", out_a, 1);
  endtask

  task automatic t_collide;
    int m = (2 + 1) * 2;
    setup(9, 2, 0, mk(0, CLR, SET, SET, NONE, NONE, NONE));
    @(negedge clk); put(4, CW'(5));
    @(negedge clk); wr_en = 1'b0;
    repeat (m - 1) @(negedge clk);
    put(4, CW'(4));
    @(negedge clk); wr_en = 1'b0;
    check("R10 trigger beats duty match", out_a, 1);
    repeat (m - 1) @(negedge clk);
    check("R8 restart keeps A high", out_a, 1);
    @(negedge clk);
    check("R8 restart then duty clear", out_a, 0);
    // period match against duty match in one tick
    setup(3, 3, 0, mk(0, CLR, SET, CLR, NONE, NONE, NONE));
    wr(4, CW'(5));
    check("R10 start level low", out_a, 0);
    repeat (40) @(negedge clk);
    check("R10 period beats duty (1)", out_a, 1);
    repeat (9) @(negedge clk);
    check("R10 period beats duty (2)", out_a, 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_trigger();
    t_divs();
    t_slow();
    t_invert();
    t_dual();
    t_static();
    t_cmd();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule